// File: doc/BRIEF.md
# Serial ADC Busy-Interrupt Read Controller

This block runs one conversion-and-read cycle of a 16-bit serial converter that has a three-wire interface with a chip-select-style convert line and a busy indication on its data line. When the host logic pulses `start_i`, the controller raises the convert line for a programmable number of system clocks. That number must be shorter than the converter's minimum conversion time. The controller then lowers the line again and keeps it low. While the converter works, its data output floats and an external pull-up holds the line high. The data output driving the line low marks the end of conversion.

The data line passes through a two-flop synchroniser. Once the synchronised line reads low, the controller generates a divided serial clock that idles low. It shifts the result in MSB first, sampling each bit at the end of the low phase that follows the falling edge that launched it. An optional extra clock pulse after the last bit makes the converter release the line. The finished word appears on a parallel output with a one-cycle valid strobe. If the line never drops, a timeout ends the transaction with a one-cycle error pulse.

Top module: `adc_busy_reader`

## Requirements
- R1: After reset and between transactions, `cnv_o`, `sclk_o`, `busy_o`, `valid_o` and `err_o` are all 0.
- R2: An accepted start holds `cnv_o` high for exactly CNV_HIGH_CYC consecutive cycles. `cnv_o` then stays low for the rest of the transaction, and `cnv_o` and `sclk_o` are never high together.
- R3: No serial clock edge is produced before the synchronised data line has been seen low after the convert pulse.
- R4: A read gives exactly DATA_W falling edges on `sclk_o` when `tail_en_i` was 0 at start, and DATA_W+1 when it was 1. Each high phase lasts CLK_DIV cycles.
- R5: `sample_o` holds the DATA_W bits in the order they arrive on the line. The first bit received, launched by the first falling edge, is bit DATA_W-1.
- R6: `valid_o` is high for exactly one cycle per successful read. `busy_o` is high from the cycle after the accepted start until that cycle, and is 0 in the cycle where `valid_o` is 1.
- R7: If the line stays high for TIMEOUT_CYC cycles after the convert line falls, `err_o` pulses for one cycle with no serial clocks and no `valid_o`. `busy_o` is then high for exactly CNV_HIGH_CYC+TIMEOUT_CYC cycles.
- R8: `start_i` is ignored while a transaction is in progress: it causes no further rising edge on `cnv_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion and read |
| tail_en_i | input | 1 | Captured at start: add the extra line-release clock pulse |
| sdo_i | input | 1 | Converter data line (pulled up when released) |
| cnv_o | output | 1 | Convert line to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| sample_o | output | DATA_W | Last captured sample |
| valid_o | output | 1 | One-cycle strobe: `sample_o` is new |
| busy_o | output | 1 | Transaction in progress |
| err_o | output | 1 | One-cycle strobe: end of conversion never seen |

## Verification
The hardest situation to reach is a read that begins right after a read without the release pulse. In that case the converter is still driving the last bit onto the line, possibly low, when the next convert pulse starts. The controller must not take that stale low as end of conversion. The bench models the converter with a pulled-up, releasable line and varies the conversion delays. It runs back-to-back reads that alternate the release pulse over walking-one words that leave bit 0 low, so a stale low is present at the next start. It also runs reads in which the converter never answers, which drives the timeout path.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNV,
        ST_WAIT,
        ST_SCKH,
        ST_SCKL,
        ST_DONE
    } rd_state_e;

    // Registered pins toward the converter.
    typedef struct packed {
        logic cnv;
        logic sclk;
    } line_t;

    localparam line_t LINES_IDLE = '{cnv: 1'b0, sclk: 1'b0};

    // Width of a counter that must reach n-1.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adcrd_sync.sv
module adcrd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= RST_VAL;
                else     chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{RST_VAL}};
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adcrd_shifter.sv
module adcrd_shifter #(
    parameter int W = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic          bit_i,
    output logic [W-1:0]  word_o,
    output logic [CW-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            word_o  <= '0;
            count_o <= '0;
        end else if (en_i) begin
            word_o  <= {word_o[W-2:0], bit_i};
            count_o <= count_o + CW'(1);
        end
    end

    // R5
    bit_budget_chk: assert property (@(posedge clk) disable iff (rst)
        count_o <= CW'(W));
endmodule

// File: rtl/adc_busy_reader.sv
module adc_busy_reader
    import adcrd_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int CLK_DIV      = 4,
    parameter int CNV_HIGH_CYC = 6,
    parameter int TIMEOUT_CYC  = 400,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              tail_en_i,
    input  logic              sdo_i,
    output logic              cnv_o,
    output logic              sclk_o,
    output logic [DATA_W-1:0] sample_o,
    output logic              valid_o,
    output logic              busy_o,
    output logic              err_o
);
    localparam int TW  = cnt_w(max3(CLK_DIV, CNV_HIGH_CYC, TIMEOUT_CYC));
    localparam int BCW = $clog2(DATA_W + 1);

    rd_state_e       state_q;
    logic [TW-1:0]   tick_q;
    line_t           lines_q;
    logic            tail_q;
    logic            in_tail_q;
    logic            line_s;
    logic            sh_en;
    logic            sh_clr;
    logic [DATA_W-1:0] word;
    logic [BCW-1:0]  nbits;
    logic            phase_end;

    adcrd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sdo_i),
        .q_o (line_s)
    );

    assign phase_end = (tick_q == TW'(CLK_DIV - 1));
    assign sh_clr    = (state_q == ST_IDLE) && start_i;
    assign sh_en     = (state_q == ST_SCKL) && phase_end && !in_tail_q;

    adcrd_shifter #(.W(DATA_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (sh_clr),
        .en_i    (sh_en),
        .bit_i   (line_s),
        .word_o  (word),
        .count_o (nbits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            tick_q    <= '0;
            lines_q   <= LINES_IDLE;
            tail_q    <= 1'b0;
            in_tail_q <= 1'b0;
            busy_o    <= 1'b0;
            valid_o   <= 1'b0;
            err_o     <= 1'b0;
            sample_o  <= '0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q     <= ST_CNV;
                        tick_q      <= '0;
                        lines_q.cnv <= 1'b1;
                        tail_q      <= tail_en_i;
                        in_tail_q   <= 1'b0;
                        busy_o      <= 1'b1;
                    end
                end
                ST_CNV: begin
                    if (tick_q == TW'(CNV_HIGH_CYC - 1)) begin
                        lines_q.cnv <= 1'b0;
                        tick_q      <= '0;
                        state_q     <= ST_WAIT;
                    end else begin
                        tick_q <= tick_q + TW'(1);
                    end
                end
                ST_WAIT: begin
                    if (!line_s) begin
                        lines_q.sclk <= 1'b1;
                        tick_q       <= '0;
                        state_q      <= ST_SCKH;
                    end else if (tick_q == TW'(TIMEOUT_CYC - 1)) begin
                        err_o   <= 1'b1;
                        busy_o  <= 1'b0;
                        state_q <= ST_IDLE;
                    end else begin
                        tick_q <= tick_q + TW'(1);
                    end
                end
                ST_SCKH: begin
                    if (phase_end) begin
                        lines_q.sclk <= 1'b0;
                        tick_q       <= '0;
                        state_q      <= ST_SCKL;
                    end else begin
                        tick_q <= tick_q + TW'(1);
                    end
                end
                ST_SCKL: begin
                    if (phase_end) begin
                        tick_q <= '0;
                        if (in_tail_q) begin
                            state_q <= ST_DONE;
                        end else if (nbits == BCW'(DATA_W - 1)) begin
                            if (tail_q) begin
                                in_tail_q    <= 1'b1;
                                lines_q.sclk <= 1'b1;
                                state_q      <= ST_SCKH;
                            end else begin
                                state_q <= ST_DONE;
                            end
                        end else begin
                            lines_q.sclk <= 1'b1;
                            state_q      <= ST_SCKH;
                        end
                    end else begin
                        tick_q <= tick_q + TW'(1);
                    end
                end
                ST_DONE: begin
                    sample_o <= word;
                    valid_o  <= 1'b1;
                    busy_o   <= 1'b0;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cnv_o  = lines_q.cnv;
    assign sclk_o = lines_q.sclk;

    // Run length of the convert pulse, for the window check.
    logic [TW:0] cnv_run_q;
    always_ff @(posedge clk) begin
        if (rst)        cnv_run_q <= '0;
        else if (cnv_o) cnv_run_q <= cnv_run_q + (TW+1)'(1);
        else            cnv_run_q <= '0;
    end

    // R2
    cnv_window_chk: assert property (@(posedge clk) disable iff (rst)
        cnv_run_q <= (TW+1)'(CNV_HIGH_CYC));
    // R2
    cnv_sclk_excl_chk: assert property (@(posedge clk) disable iff (rst)
        cnv_o |-> !sclk_o);
    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    // R6
    valid_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (!busy_o && $past(busy_o)));
    // R7
    err_valid_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(err_o && valid_o));
    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && start_i) |=> !$rose(cnv_o));
endmodule

// File: tb/tb_adc_busy_reader.sv
module tb_adc_busy_reader;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = CLK_PERIOD / 4;
    localparam int DW         = 16;
    localparam int DIV        = 5;
    localparam int CNVH       = 6;
    localparam int TMO        = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic tail_en = 1'b0;
    logic cnv, sclk, valid, busy, err;
    logic [DW-1:0] sample;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Converter model: pulled-up line, released during conversion.
    logic          m_oe = 1'b0;
    logic          m_drv = 1'b1;
    wire           sdo_line = m_oe ? m_drv : 1'b1;
    int            m_conv_time = 20;
    logic [DW-1:0] m_word = '0;
    int            m_left = 0;
    int            m_falls = 0;
    logic          m_conv = 1'b0;
    logic          m_read = 1'b0;
    logic          cnv_d = 1'b0;
    logic          sclk_d = 1'b0;

    adc_busy_reader #(
        .DATA_W(DW), .CLK_DIV(DIV), .CNV_HIGH_CYC(CNVH), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst(rst), .start_i(start), .tail_en_i(tail_en), .sdo_i(sdo_line),
        .cnv_o(cnv), .sclk_o(sclk), .sample_o(sample), .valid_o(valid),
        .busy_o(busy), .err_o(err)
    );

    always @(posedge clk) begin
        cnv_d  <= cnv;
        sclk_d <= sclk;
        if (rst) begin
            m_oe <= 1'b0; m_conv <= 1'b0; m_read <= 1'b0; m_drv <= 1'b1;
        end else if (cnv && !cnv_d) begin
            m_oe <= 1'b0; m_read <= 1'b0;
            m_conv <= (m_conv_time > 0);
            m_left <= m_conv_time;
        end else if (m_conv) begin
            if (m_left <= 1) begin
                m_oe <= 1'b1; m_drv <= 1'b0; m_conv <= 1'b0;
                m_read <= 1'b1; m_falls <= 0;
            end else begin
                m_left <= m_left - 1;
            end
        end else if (m_read && sclk_d && !sclk) begin
            if (m_falls < DW) m_drv <= m_word[DW-1-m_falls];
            else begin m_oe <= 1'b0; m_read <= 1'b0; end
            m_falls <= m_falls + 1;
        end
    end

    int n_checks = 0;
    int n_errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor, sampled mid-cycle.
    int mon_cnv_hi = 0, mon_rises = 0, mon_falls = 0, mon_valid = 0;
    int mon_err = 0, mon_busy = 0, sclk_run = 0;
    logic [DW-1:0] mon_sample = '0;
    logic cnv_p = 1'b0, sclk_p = 1'b0, busy_p = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cnv) mon_cnv_hi++;
            if (cnv && !cnv_p) mon_rises++;
            if (busy) mon_busy++;
            if (err) mon_err++;
            if (sclk) sclk_run++;
            else if (sclk_p) begin
                mon_falls++;
                // R4 high phase length
                chk(sclk_run == DIV, "R4", "sclk high phase", sclk_run, DIV);
                // R3 no clock while the converter is still busy
                chk(!m_conv, "R3", "sclk edge during conversion", m_conv, 0);
                sclk_run = 0;
            end
            if (valid) begin
                mon_valid++;
                mon_sample = sample;
                // R6 busy drops as valid rises
                chk(!busy && busy_p, "R6", "busy around valid", {busy_p, busy}, 2);
            end
        end
        cnv_p  = cnv;
        sclk_p = sclk;
        busy_p = busy;
    end

    task automatic step();
        @(posedge clk);
        #Q;
    endtask

    task automatic check_idle(input string req);
        chk(!cnv && !sclk && !busy && !valid && !err, req, "idle outputs",
            {cnv, sclk, busy, valid, err}, 0);
    endtask

    task automatic run_read(input logic [DW-1:0] word, input int conv_t,
                            input bit tail, input bit poke);
        int r0, f0, h0, v0, e0, b0, waited;
        r0 = mon_rises; f0 = mon_falls; h0 = mon_cnv_hi;
        v0 = mon_valid; e0 = mon_err;  b0 = mon_busy;
        m_word = word;
        m_conv_time = conv_t;
        start = 1'b1; tail_en = tail;
        step();
        start = 1'b0; tail_en = 1'b0;
        waited = 0;
        while (mon_valid == v0 && mon_err == e0 && waited < 3000) begin
            step();
            waited++;
            if (poke && (waited == 40 || waited == 20 + conv_t)) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        repeat (8) step();
        if (conv_t > 0) begin
            chk(mon_valid - v0 == 1, "R6", "valid pulses", mon_valid - v0, 1);
            chk(mon_err == e0, "R7", "no error on good read", mon_err - e0, 0);
            chk(mon_sample == word, "R5", "captured sample", mon_sample, word);
            chk(mon_falls - f0 == DW + int'(tail), "R4", "falling edges",
                mon_falls - f0, DW + int'(tail));
        end else begin
            chk(mon_err - e0 == 1, "R7", "error pulses", mon_err - e0, 1);
            chk(mon_valid == v0, "R7", "no valid on timeout", mon_valid - v0, 0);
            chk(mon_falls == f0, "R3", "no sclk without end of conversion",
                mon_falls - f0, 0);
            chk(mon_busy - b0 == CNVH + TMO, "R7", "busy span to timeout",
                mon_busy - b0, CNVH + TMO);
        end
        chk(mon_cnv_hi - h0 == CNVH, "R2", "convert pulse width", mon_cnv_hi - h0, CNVH);
        chk(mon_rises - r0 == 1, "R8", "convert rises per transaction", mon_rises - r0, 1);
        check_idle("R1");
    endtask

    initial begin
        repeat (4) step();
        rst = 1'b0;
        step();
        check_idle("R1");
        // Walking ones: bit 0 low leaves a stale low on the line for the next start.
        for (int i = 0; i < DW; i++)
            run_read(DW'(1) << i, 10 + 7 * i, i[0], 1'b0);
        run_read(16'h0000, 30, 1'b0, 1'b1);
        run_read(16'hFFFF, 30, 1'b1, 1'b1);
        run_read(16'hAAAA, 150, 1'b0, 1'b1);
        run_read(16'h5555, 12, 1'b1, 1'b1);
        run_read(16'h8000, 60, 1'b0, 1'b0);
        begin
            logic [DW-1:0] lf;
            lf = 16'hACE1;
            for (int k = 0; k < 8; k++) begin
                lf = {lf[DW-2:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                run_read(lf, 25 + 13 * k, k[1], k[0]);
            end
        end
        run_read(16'h1234, -1, 1'b0, 1'b0);
        run_read(16'h4321, -1, 1'b1, 1'b1);
        run_read(16'h0F0F, 40, 1'b0, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule